// File: doc/BRIEF.md
# Palette-port extended register unlock sequencer

This block sits behind the four byte-wide ports of a standard colour palette and hides two extra resources there: an 8-bit command byte that selects the pixel depth, and a bank of sixteen 16-bit clock-synthesiser entries. Normally every access goes straight on to the standard palette logic through a pass-through strobe. The host can unlock the hidden resources only with a counted run of back-to-back reads of the mask port. The fourth such read answers with an identification byte and turns on extended mode. The fifth read returns the command byte.

In extended mode the two index ports load separate read and write pointers into the clock bank. The data port moves one byte per access, low byte first and then high byte, and the pointer steps after each high byte. The block also decodes the current command byte into a pixel depth. For an entry picked by a lookup select, it presents the multiplier, divider and post-divider fields of the clock synthesiser.

Top module: `pal_ext_unlock`

## Requirements
- R1: Port codes on `port_sel_i` are 0 = mask, 1 = read index, 2 = write index, 3 = data. Each read of the mask port steps an unlock count that starts at 0 after reset. Mask reads made while the count is 0, 1 or 2 are passed through, returning `pt_rdata_i` with `pt_stb_o` high.
- R2: A mask read made while the count is 3 returns 0x70 and turns extended mode on.
- R3: A mask read made while the count is 4 returns the command byte and sets the count back to 0. Neither of these two reads strobes the pass-through.
- R4: Writing 0xFF to the mask port turns extended mode off, clears the count and is passed through. Any other mask write made while the count is 4 loads the command byte and is not passed through. At other counts the write is only passed through.
- R5: Any access to the read index, write index or data port sets the count to 0.
- R6: `depth_o` follows command bits 7:4. Codes 2, 3 and A give 15; 4 and E give 24; 5, 6 and C give 16; 7 gives 32; every other code gives 8. The value takes effect from the clock edge of the loading write.
- R7: In extended mode, a write to the read or write index port loads that 4-bit pointer from data bits 3:0. A read of that port returns the pointer, zero-extended.
- R8: In extended mode, data accesses alternate between byte 7:0 and byte 15:8 of the entry under the pointer (the write pointer for writes, the read pointer for reads). A single toggle is shared by reads and writes. The pointer advances after each high byte and wraps from 15 to 0.
- R9: Any mask-port read resets the byte toggle so that the next data access uses the low byte.
- R10: For the entry chosen by `lkp_sel_i`, `m_o` equals bits 6:0 plus 2, `n1_o` equals bits 12:8 plus 2, and `n2_o` equals bits 15:13.
- R11: Outside extended mode, index and data accesses are passed through. In extended mode they are serviced internally without a strobe. On a read that is passed through, `rdata_o` equals `pt_rdata_i`, and `rdata_o` is 0 when there is no read.
- R12: After reset, extended mode is off, the count and toggle are 0, and the command byte, both pointers and all bank entries are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_i | input | 1 | Access strobe, one per cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| port_sel_i | input | 2 | Port code (see R1) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the access cycle |
| pt_stb_o | output | 1 | Forward this access to the standard palette |
| pt_rdata_i | input | 8 | Read data from the standard palette |
| depth_o | output | 6 | Decoded bits per pixel |
| lkp_sel_i | input | 4 | Clock entry to decode |
| m_o | output | 8 | Multiplier field plus 2 |
| n1_o | output | 6 | Divider field plus 2 |
| n2_o | output | 3 | Post-divider exponent |

## Verification
The unlock path is tried with runs of one to five mask reads. Some runs are cut short by an access to another port or by a 0xFF write, which separates a count that resets correctly from one that only saturates. All sixteen command nibbles are loaded and read back, and this covers every depth group. Byte-pair traffic crosses the pointer wrap from 15 to 0, and a mask read placed between the two halves of a pair shows whether the toggle is shared and whether it is cleared. A long seeded random mix of ports, directions and data values is then run against a bench model of the requirements.

// File: rtl/pal_ext_pkg.sv
package pal_ext_pkg;
  typedef enum logic [1:0] {
    PORT_MASK = 2'd0,
    PORT_RIDX = 2'd1,
    PORT_WIDX = 2'd2,
    PORT_DATA = 2'd3
  } port_e;

  function automatic logic [5:0] depth_of(input logic [3:0] code);
    logic [5:0] d;
    case (code)
      4'h2, 4'h3, 4'hA: d = 6'd15;
      4'h4, 4'hE:       d = 6'd24;
      4'h5, 4'h6, 4'hC: d = 6'd16;
      4'h7:             d = 6'd32;
      default:          d = 6'd8;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/pal_ext_unlock_seq.sv
module pal_ext_unlock_seq
  import pal_ext_pkg::*;
#(
  parameter int          UNLOCK_RDS = 4,
  parameter logic [7:0]  CLR_CODE   = 8'hFF,
  localparam int         CNT_W      = $clog2(UNLOCK_RDS + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             wr_i,
  input  port_e            sel_i,
  input  logic [7:0]       wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ext_o,
  output logic [7:0]       cmd_o,
  output logic             id_hit_o,
  output logic             cmd_hit_o,
  output logic             cmd_ld_o
);
  localparam logic [CNT_W-1:0] ID_AT  = CNT_W'(UNLOCK_RDS - 1);
  localparam logic [CNT_W-1:0] CMD_AT = CNT_W'(UNLOCK_RDS);

  logic [CNT_W-1:0] cnt_q;
  logic ext_q;
  logic [7:0] cmd_q;
  logic mask_rd, mask_wr, other, clr;

  assign mask_rd   = acc_i && !wr_i && sel_i == PORT_MASK;
  assign mask_wr   = acc_i &&  wr_i && sel_i == PORT_MASK;
  assign other     = acc_i && sel_i != PORT_MASK;
  assign clr       = mask_wr && wdata_i == CLR_CODE;
  assign id_hit_o  = mask_rd && cnt_q == ID_AT;
  assign cmd_hit_o = mask_rd && cnt_q == CMD_AT;
  assign cmd_ld_o  = mask_wr && !clr && cnt_q == CMD_AT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ext_q <= 1'b0;
      cmd_q <= '0;
    end else begin
      if (clr || other || cmd_hit_o) cnt_q <= '0;
      else if (mask_rd)              cnt_q <= cnt_q + 1'b1;
      if (clr)           ext_q <= 1'b0;
      else if (id_hit_o) ext_q <= 1'b1;
      if (cmd_ld_o) cmd_q <= wdata_i;
    end
  end

  assign cnt_o = cnt_q;
  assign ext_o = ext_q;
  assign cmd_o = cmd_q;
endmodule

// File: rtl/pal_ext_clk_bank.sv
module pal_ext_clk_bank
  import pal_ext_pkg::*;
#(
  parameter int  N_ENT = 16,
  localparam int IW    = $clog2(N_ENT),
  localparam int DW    = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ext_i,
  input  logic          acc_i,
  input  logic          wr_i,
  input  port_e         sel_i,
  input  logic [7:0]    wdata_i,
  input  logic [IW-1:0] lkp_sel_i,
  output logic [7:0]    rd_byte_o,
  output logic          hi_o,
  output logic [DW-1:0] lkp_o
);
  logic [DW-1:0] ent_q [N_ENT];
  logic [IW-1:0] ridx_q, widx_q;
  logic hi_q;
  logic dat_acc, ff_clr;

  assign dat_acc = ext_i && acc_i && sel_i == PORT_DATA;
  assign ff_clr  = acc_i && !wr_i && sel_i == PORT_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ridx_q <= '0;
      widx_q <= '0;
      hi_q   <= 1'b0;
    end else begin
      if (ff_clr)       hi_q <= 1'b0;
      else if (dat_acc) hi_q <= !hi_q;
      if (ext_i && acc_i && wr_i && sel_i == PORT_RIDX) ridx_q <= wdata_i[IW-1:0];
      if (ext_i && acc_i && wr_i && sel_i == PORT_WIDX) widx_q <= wdata_i[IW-1:0];
      if (dat_acc && hi_q) begin
        if (wr_i) widx_q <= widx_q + 1'b1;
        else      ridx_q <= ridx_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q[g] <= '0;
      else if (dat_acc && wr_i && widx_q == IW'(g)) begin
        if (hi_q) ent_q[g][15:8] <= wdata_i;
        else      ent_q[g][7:0]  <= wdata_i;
      end
    end
  end

  always_comb begin
    case (sel_i)
      PORT_DATA: rd_byte_o = hi_q ? ent_q[ridx_q][15:8] : ent_q[ridx_q][7:0];
      PORT_RIDX: rd_byte_o = 8'(ridx_q);
      PORT_WIDX: rd_byte_o = 8'(widx_q);
      default:   rd_byte_o = '0;
    endcase
  end

  assign hi_o  = hi_q;
  assign lkp_o = ent_q[lkp_sel_i];
endmodule

// File: rtl/pal_ext_clk_fields.sv
module pal_ext_clk_fields (
  input  logic [15:0] ent_i,
  output logic [7:0]  m_o,
  output logic [5:0]  n1_o,
  output logic [2:0]  n2_o
);
  assign m_o  = {1'b0, ent_i[6:0]} + 8'd2;
  assign n1_o = {1'b0, ent_i[12:8]} + 6'd2;
  assign n2_o = ent_i[15:13];
endmodule

// File: rtl/pal_ext_unlock.sv
module pal_ext_unlock
  import pal_ext_pkg::*;
#(
  parameter int         N_ENT      = 16,
  parameter int         UNLOCK_RDS = 4,
  parameter logic [7:0] ID_BYTE    = 8'h70,
  localparam int        IW         = $clog2(N_ENT),
  localparam int        CNT_W      = $clog2(UNLOCK_RDS + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic          wr_i,
  input  logic [1:0]    port_sel_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  output logic          pt_stb_o,
  input  logic [7:0]    pt_rdata_i,
  output logic [5:0]    depth_o,
  input  logic [IW-1:0] lkp_sel_i,
  output logic [7:0]    m_o,
  output logic [5:0]    n1_o,
  output logic [2:0]    n2_o
);
  port_e sel;
  logic [CNT_W-1:0] cnt_w;
  logic ext_w, id_hit, cmd_hit, cmd_ld, hi_w;
  logic [7:0] cmd_w, bank_byte;
  logic [15:0] lkp_ent;
  logic ext_svc;

  assign sel = port_e'(port_sel_i);

  pal_ext_unlock_seq #(.UNLOCK_RDS(UNLOCK_RDS)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc_i), .wr_i(wr_i), .sel_i(sel),
    .wdata_i(wdata_i), .cnt_o(cnt_w), .ext_o(ext_w), .cmd_o(cmd_w),
    .id_hit_o(id_hit), .cmd_hit_o(cmd_hit), .cmd_ld_o(cmd_ld)
  );

  pal_ext_clk_bank #(.N_ENT(N_ENT)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_i(ext_w), .acc_i(acc_i), .wr_i(wr_i),
    .sel_i(sel), .wdata_i(wdata_i), .lkp_sel_i(lkp_sel_i),
    .rd_byte_o(bank_byte), .hi_o(hi_w), .lkp_o(lkp_ent)
  );

  pal_ext_clk_fields u_fld (.ent_i(lkp_ent), .m_o(m_o), .n1_o(n1_o), .n2_o(n2_o));

  assign ext_svc  = ext_w && sel != PORT_MASK;
  assign pt_stb_o = acc_i && !(id_hit || cmd_hit || cmd_ld || ext_svc);
  assign depth_o  = depth_of(cmd_w[7:4]);

  always_comb begin
    if (!acc_i || wr_i) rdata_o = '0;
    else if (id_hit)    rdata_o = ID_BYTE;
    else if (cmd_hit)   rdata_o = cmd_w;
    else if (ext_svc)   rdata_o = bank_byte;
    else                rdata_o = pt_rdata_i;
  end
endmodule

// File: rtl/pal_ext_unlock_chk.sv
module pal_ext_unlock_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_i,
  input logic             wr_i,
  input logic [1:0]       port_sel_i,
  input logic [7:0]       wdata_i,
  input logic [7:0]       rdata_o,
  input logic             pt_stb_o,
  input logic [CNT_W-1:0] cnt_w,
  input logic             ext_w,
  input logic             hi_w
);
  logic mrd;
  assign mrd = acc_i && !wr_i && port_sel_i == 2'd0;

  a_r1_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_w <= CNT_W'(4));
  a_r1_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrd && cnt_w < CNT_W'(4) |=> cnt_w == $past(cnt_w) + 1'b1);
  a_r2_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrd && cnt_w == CNT_W'(3) |-> rdata_o == 8'h70 && !pt_stb_o ##1 ext_w);
  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrd && cnt_w == CNT_W'(4) |=> cnt_w == '0);
  a_r4_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && wr_i && port_sel_i == 2'd0 && wdata_i == 8'hFF |=> !ext_w && cnt_w == '0);
  a_r5_other: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && port_sel_i != 2'd0 |=> cnt_w == '0);
  a_r9_ff_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrd |=> !hi_w);
  a_r11_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |-> !pt_stb_o && rdata_o == '0);
endmodule

bind pal_ext_unlock pal_ext_unlock_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc_i), .wr_i(wr_i),
  .port_sel_i(port_sel_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .pt_stb_o(pt_stb_o), .cnt_w(cnt_w), .ext_w(ext_w), .hi_w(hi_w)
);

// File: tb/pal_ext_unlock_test.sv
module pal_ext_unlock_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc = 1'b0, wr = 1'b0;
  logic [1:0] psel = '0;
  logic [7:0] wd = '0, ptd = '0, rd;
  logic pt;
  logic [5:0] depth;
  logic [3:0] lsel = '0;
  logic [7:0] m;
  logic [5:0] n1;
  logic [2:0] n2;

  int checks = 0, errors = 0;

  // bench model
  int mcnt;
  bit mext, mhi;
  logic [7:0] mcmd;
  logic [15:0] mbank [16];
  logic [3:0] mridx, mwidx;

  always #(CLK_PERIOD/2) clk = ~clk;

  pal_ext_unlock uut (
    .clk_i(clk), .rst_ni(rst_n), .acc_i(acc), .wr_i(wr), .port_sel_i(psel),
    .wdata_i(wd), .rdata_o(rd), .pt_stb_o(pt), .pt_rdata_i(ptd),
    .depth_o(depth), .lkp_sel_i(lsel), .m_o(m), .n1_o(n1), .n2_o(n2)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_depth(input logic [3:0] c);
    case (c)
      4'h2, 4'h3, 4'hA: return 6'd15;
      4'h4, 4'hE:       return 6'd24;
      4'h5, 4'h6, 4'hC: return 6'd16;
      4'h7:             return 6'd32;
      default:          return 6'd8;
    endcase
  endfunction

  task automatic model_reset();
    mcnt = 0; mext = 0; mhi = 0; mcmd = '0; mridx = '0; mwidx = '0;
    for (int i = 0; i < 16; i++) mbank[i] = '0;
  endtask

  task automatic check_outs();
    lsel = 4'($urandom_range(0, 15));
    #1;
    check("R6 depth", depth, exp_depth(mcmd[7:4]));
    check("R10 m", m, {1'b0, mbank[lsel][6:0]} + 8'd2);
    check("R10 n1", n1, {1'b0, mbank[lsel][12:8]} + 6'd2);
    check("R10 n2", n2, mbank[lsel][15:13]);
  endtask

  // one access: expected computed from the pre-edge model, model advanced after
  task automatic access(input logic [1:0] s, input bit w, input logic [7:0] d);
    logic [7:0] erd;
    bit ept;
    string tag;
    @(negedge clk);
    acc = 1'b1; wr = w; psel = s; wd = d; ptd = 8'($urandom);
    #1;
    ept = 1; erd = ptd; tag = "R11 pass";
    if (s == 2'd0) begin
      if (!w && mcnt == 3)      begin ept = 0; erd = 8'h70; tag = "R2 id"; end
      else if (!w && mcnt == 4) begin ept = 0; erd = mcmd;  tag = "R3 cmd"; end
      else if (w && d != 8'hFF && mcnt == 4) begin ept = 0; tag = "R4 load"; end
      else if (!w) tag = "R1 pass";
    end else if (mext) begin
      ept = 0;
      if (s == 2'd1)      begin erd = 8'(mridx); tag = "R7 ridx"; end
      else if (s == 2'd2) begin erd = 8'(mwidx); tag = "R7 widx"; end
      else begin erd = mhi ? mbank[mridx][15:8] : mbank[mridx][7:0]; tag = "R8 data"; end
    end
    if (w) erd = 8'h00;
    check(tag, rd, erd);
    check({tag, " strobe"}, pt, ept);
    // next state
    if (s == 2'd0) begin
      if (!w) begin
        mhi = 0;
        if (mcnt == 3) mext = 1;
        mcnt = (mcnt == 4) ? 0 : mcnt + 1;
      end else if (d == 8'hFF) begin
        mext = 0; mcnt = 0;
      end else if (mcnt == 4) mcmd = d;
    end else begin
      mcnt = 0;
      if (mext) begin
        if (s == 2'd1 && w) mridx = d[3:0];
        if (s == 2'd2 && w) mwidx = d[3:0];
        if (s == 2'd3) begin
          if (w) begin
            if (mhi) mbank[mwidx][15:8] = d; else mbank[mwidx][7:0] = d;
            if (mhi) mwidx++;
          end else if (mhi) mridx++;
          mhi = !mhi;
        end
      end
    end
    @(posedge clk);
    #1;
    acc = 1'b0;
    check_outs();
  endtask

  task automatic unlock();
    for (int i = 0; i < 4; i++) access(2'd0, 0, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1729));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    check("R12 depth", depth, 6'd8);
    check("R12 m", m, 8'd2);
    check("R12 n1", n1, 6'd2);
    check("R12 n2", n2, 3'd0);
    check("R12 idle strobe", pt, 1'b0);
    rst_n = 1'b1;

    // R1/R2/R3: full sequence returning command 0
    unlock();
    access(2'd0, 0, 8'h00);
    // R5: interrupted sequence restarts
    access(2'd0, 0, 8'h00); access(2'd0, 0, 8'h00);
    access(2'd1, 0, 8'h00);
    access(2'd0, 0, 8'h00); access(2'd0, 0, 8'h00); access(2'd0, 0, 8'h00);
    access(2'd0, 0, 8'h00);
    access(2'd0, 1, 8'hFF); // R4 lock

    // R6: every command nibble
    for (int c = 0; c < 16; c++) begin
      unlock();
      access(2'd0, 1, 8'((c << 4) | 5));
      access(2'd0, 0, 8'h00);
    end

    // R7/R8: byte pairs across the pointer wrap
    unlock();
    access(2'd2, 1, 8'h0F);
    access(2'd2, 0, 8'h00);
    for (int i = 0; i < 4; i++) access(2'd3, 1, 8'hA0 + 8'(i));
    access(2'd1, 1, 8'h0F);
    for (int i = 0; i < 4; i++) access(2'd3, 0, 8'h00);
    access(2'd1, 0, 8'h00);
    // R9: mask read between halves resets toggle
    access(2'd3, 1, 8'h11);
    access(2'd0, 0, 8'h00);
    access(2'd3, 1, 8'h22);
    access(2'd3, 1, 8'h33);
    access(2'd0, 1, 8'hFF);
    access(2'd3, 1, 8'h44); // R11 passed through when locked

    // mixed random
    for (int k = 0; k < 4000; k++) begin
      int r;
      logic [1:0] s;
      bit w;
      logic [7:0] d;
      r = $urandom_range(0, 99);
      s = (r < 55) ? 2'd0 : 2'($urandom_range(1, 3));
      w = ($urandom_range(0, 99) < 35);
      d = ($urandom_range(0, 19) == 0) ? 8'hFF : 8'($urandom);
      access(s, w, d);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule